// File: doc/BRIEF.md
# Program-Status Read Path

This block is the device-side output stage that drives the 8-bit data bus of a page-programmable nonvolatile memory. When no internal programming cycle is running, a read returns the byte supplied by the array. While programming is running, a read instead returns a status byte that the host can poll.

In the status byte, bit 7 carries the complement of bit 7 of the byte loaded last, so the host can compare it against the value it wrote. Bit 6 flips on every read access, and bits 5..0 are zero. The write sequencer supplies the busy flag and the polling bit. The array supplies its read data. The block returns a registered data word and a registered output-enable flag, from which the pad ring builds the tri-state bus.

All inputs are sampled on the rising clock edge, and the outputs follow one edge later. A read access starts on a sampled falling edge of output enable while chip enable is low. The toggle state is cleared whenever a new programming cycle begins.

Top module: `pgm_status_rdpath`

## Requirements
- R1: `dq_oe` is 1 after an edge at which `ce_n` and `oe_n` were both sampled 0. After any other edge `dq_oe` is 0 and `dq_out` is all zeros.
- R2: When `busy` is sampled 0 during a selected read, `dq_out` equals the `array_data` sampled at that same edge.
- R3: When `busy` is sampled 1 during a selected read, `dq_out[7]` equals the inverse of `last_msb`.
- R4: When `busy` is sampled 1 during a selected read, `dq_out[5:0]` are all zero.
- R5: While busy, each read access flips `dq_out[6]`. A read access is an edge at which `oe_n` is 0, `oe_n` was 1 at the edge before, and `ce_n` is 0. The first access after programming starts returns 1. Holding `oe_n` low across further edges leaves bit 6 unchanged.
- R6: A falling `oe_n` while `ce_n` is high is not a read access and does not advance the toggle.
- R7: A rising edge of `busy` clears the toggle, so the first read of every programming cycle returns bit 6 = 1, whatever happened in earlier cycles.
- R8: After `busy` returns to 0, every read returns the full `array_data` byte, including bits 7 and 6, and bit 6 no longer changes.
- R9: While reset is asserted, and for the synchronizer latency after it is released, `dq_oe` and `dq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| last_msb | input | 1 | Bit 7 of the most recently loaded data byte |
| array_data | input | 8 | Array read data |
| dq_out | output | 8 | Data to drive on the bus |
| dq_oe | output | 1 | Drive enable for the bus; bus is high impedance when 0 |

## Verification
The hardest situations to reach are the ones that depend on the toggle's history. These are a phantom output-enable pulse with chip enable high, an output enable held low across several edges, and a second programming cycle that follows a cycle with an odd number of reads. In each case a wrong design looks correct on a single read. For every value of the loaded byte, the stimulus runs a full programming cycle with three counted reads, a phantom pulse and a long held read. It then ends the cycle and checks the readback, and starts a fresh cycle to confirm that the toggle was cleared. The bench tracks the expected toggle phase arithmetically from the number of accesses.

// File: rtl/pgm_status_rdpath_pkg.sv
package pgm_status_rdpath_pkg;
  // Source selected for the registered output word
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } out_src_e;
endpackage

// File: rtl/pgm_status_rst_sync.sv
module pgm_status_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pgm_status_access_det.sv
module pgm_status_access_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic busy,
  output logic selected,
  output logic access_start,
  output logic busy_rise
);
  logic oe_n_q, oe_n_d;
  logic busy_q, busy_d;

  always_comb begin
    oe_n_d = oe_n;
    busy_d = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_n_q <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      oe_n_q <= oe_n_d;
      busy_q <= busy_d;
    end
  end

  assign selected     = ~ce_n & ~oe_n;
  assign access_start = selected & oe_n_q;
  assign busy_rise    = busy & ~busy_q;
endmodule

// File: rtl/pgm_status_toggle.sv
module pgm_status_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic busy_rise,
  input  logic access_start,
  output logic tgl_next
);
  logic tgl_q;
  logic tgl_base;
  logic tgl_adv;

  always_comb begin
    tgl_base = busy_rise ? 1'b0 : tgl_q;
    tgl_adv  = access_start & busy;
    tgl_next = tgl_adv ? ~tgl_base : tgl_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_next;
  end
endmodule

// File: rtl/pgm_status_out_mux.sv
module pgm_status_out_mux
  import pgm_status_rdpath_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selected,
  input  logic              busy,
  input  logic              last_msb,
  input  logic              tgl_next,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  out_src_e          src;
  logic [DATA_W-1:0] dq_d;
  logic [DATA_W-1:0] dq_q;
  logic              oe_q;

  always_comb begin
    if (!selected)  src = SRC_NONE;
    else if (busy)  src = SRC_STATUS;
    else            src = SRC_ARRAY;
  end

  always_comb begin
    dq_d = '0;
    case (src)
      SRC_ARRAY: dq_d = array_data;
      SRC_STATUS: begin
        dq_d[POLL_BIT] = ~last_msb;
        dq_d[TOG_BIT]  = tgl_next;
      end
      default: dq_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      dq_q <= dq_d;
      oe_q <= selected;
    end
  end

  assign dq_out = dq_q;
  assign dq_oe  = oe_q;
endmodule

// File: rtl/pgm_status_rdpath.sv
module pgm_status_rdpath #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic              last_msb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic rst_n_sync;
  logic selected, access_start, busy_rise, tgl_next;

  pgm_status_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  pgm_status_access_det u_det (
    .clk(clk), .rst_n(rst_n_sync), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
    .selected(selected), .access_start(access_start), .busy_rise(busy_rise)
  );

  pgm_status_toggle u_tgl (
    .clk(clk), .rst_n(rst_n_sync), .busy(busy), .busy_rise(busy_rise),
    .access_start(access_start), .tgl_next(tgl_next)
  );

  pgm_status_out_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_mux (
    .clk(clk), .rst_n(rst_n_sync), .selected(selected), .busy(busy),
    .last_msb(last_msb), .tgl_next(tgl_next), .array_data(array_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/pgm_status_rdpath_chk.sv
module pgm_status_rdpath_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              busy,
  input logic              last_msb,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  AST_DRIVE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ($past(ce_n) == 1'b0 && $past(oe_n) == 1'b0)); // R1

  AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == '0); // R1

  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !$past(busy)) |-> dq_out == $past(array_data)); // R2

  AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(busy)) |-> dq_out[DATA_W-1] == ~$past(last_msb)); // R3

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(busy)) |-> dq_out[DATA_W-3:0] == '0); // R4

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe) && $past(busy) && $past(busy, 2)) |-> $stable(dq_out[DATA_W-2])); // R5
endmodule

bind pgm_status_rdpath pgm_status_rdpath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
  .last_msb(last_msb), .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/pgm_status_rdpath_tb.sv
`timescale 1ns/1ps
module pgm_status_rdpath_tb;
  logic       clk;
  logic       rst_n;
  logic       ce_n, oe_n, busy, last_msb;
  logic [7:0] array_data;
  logic [7:0] dq_out;
  logic       dq_oe;
  int         n_tests, n_fail;
  logic       exp_t;

  pgm_status_rdpath u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
    .last_msb(last_msb), .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Start a read access, sample one edge later, keep enables low
  task automatic rd_open(output logic [7:0] d, output logic e);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = dq_out; e = dq_oe;
  endtask

  task automatic rd_close();
    @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    chk("R1 deselected", {dq_oe, dq_out}, 9'h000);
  endtask

  // One status read during busy: expect toggle advanced
  task automatic busy_read(input logic lm, input string req);
    logic [7:0] d; logic e;
    rd_open(d, e);
    exp_t = ~exp_t;
    chk(req, {e, d}, {1'b1, ~lm, exp_t, 6'b0});
    rd_close();
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d; logic e;
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; busy = 1'b0; last_msb = 1'b0;
    array_data = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R9 in reset", {dq_oe, dq_out}, 9'h000);
    ce_n = 1'b1; oe_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", {dq_oe, dq_out}, 9'h000);
    repeat (3) @(negedge clk);

    // R1: enable combinations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); ce_n = c[0]; oe_n = c[1];
      @(negedge clk);
      chk("R1 enables", {dq_oe, dq_out}, (c == 0) ? {1'b1, 8'h5A} : 9'h000);
    end
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    // R2: idle reads across all array values
    for (int v = 0; v < 256; v++) begin
      array_data = 8'(v);
      rd_open(d, e);
      chk("R2 idle read", {e, d}, {1'b1, 8'(v)});
      rd_close();
    end

    // R3..R8 across all loaded-byte values
    for (int v = 0; v < 256; v++) begin
      logic lm;
      lm = v[7];
      @(negedge clk); last_msb = lm; array_data = ~8'(v); busy = 1'b1;
      exp_t = 1'b0;
      busy_read(lm, "R3 R4 R5 first read");
      busy_read(lm, "R5 second read");
      // R6: phantom output-enable pulse with chip enable high
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
      @(negedge clk);
      chk("R6 phantom drive", {dq_oe, dq_out}, 9'h000);
      oe_n = 1'b1;
      @(negedge clk);
      busy_read(lm, "R6 no advance");
      // R5: held read keeps bit 6
      rd_open(d, e);
      exp_t = ~exp_t;
      chk("R5 held start", {e, d}, {1'b1, ~lm, exp_t, 6'b0});
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R5 held", {dq_oe, dq_out}, {1'b1, ~lm, exp_t, 6'b0});
      end
      rd_close();
      // R8: programming done
      @(negedge clk); busy = 1'b0; array_data = 8'(v);
      for (int k = 0; k < 2; k++) begin
        rd_open(d, e);
        chk("R8 true data", {e, d}, {1'b1, 8'(v)});
        rd_close();
      end
      // R7: new cycle restarts toggle (exp_t ended at 0 after 4 reads; do odd count)
      @(negedge clk); busy = 1'b1;
      exp_t = 1'b0;
      busy_read(lm, "R7 restart a");
      @(negedge clk); busy = 1'b0;
      @(negedge clk); busy = 1'b1;
      exp_t = 1'b0;
      busy_read(lm, "R7 restart b");
      @(negedge clk); busy = 1'b0;
      @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule